// File: doc/BRIEF.md
# Two-Source Subvector Swizzle Unit

This unit assembles, for every element of a vector, one destination subvector of up to four lanes. Each lane is copied from either of two source subvector groups (group A or group B). A packed selector word, one per element, controls the choice. Software loads the vector length and the two subvector widths, then pulses `start`. The unit walks the elements in order, one per cycle, and reads each element's selector and both source subvectors through combinational indexed read ports. It offers the assembled subvector on a valid/ready write port.

Each destination lane owns a 3-bit field of the selector. The field's top bit picks the group and its low two bits pick the lane inside that group's subvector. A selector that sets any bit beyond the lanes in use is refused, and so is one that names a source lane beyond the source width. In either case the run stops, a sticky illegal flag is raised and the offending element index is recorded.

Back-pressure rules for the write port: once `wr_valid` is high it stays high with `wr_addr`, `wr_mask` and `wr_data` unchanged until the cycle in which `wr_ready` is also high. A write completes only on a clock edge where both are high. `wr_ready` may be low for any number of cycles. The read ports carry no handshake: their data must be valid in the cycle the address is presented and must hold still while a write stalls. `dest_sub` and `src_sub` must lie in 1..4.

Top module: `subvec_swizzle`

## Requirements
- R1: After reset, `busy`, `done`, `illegal` and `wr_valid` are all 0.
- R2: Destination lane i is controlled by selector bits [3i+2:3i]. Bit 3i+2 = 1 takes the lane from group A (`src_a_data`) and 0 takes it from group B (`src_b_data`). Bits [3i+1:3i] give the source lane number j, and source lane j sits at data bits [16j+15:16j].
- R3: For element v, `sel_addr` = v and `src_addr` = v*`src_sub`, and the write goes to `wr_addr` = v*`dest_sub`. `wr_mask` has its low `dest_sub` bits set, and data lanes at or above `dest_sub` are zero.
- R4: A selector with any 1 bit at position 3*`dest_sub` or above is a trap.
- R5: A lane i < `dest_sub` whose lane number is greater than or equal to `src_sub` is a trap.
- R6: On a trap the unit makes no write for that element or any later one. It sets `illegal`, sets `fail_elem` to the element index, pulses `done` and drops `busy`. `illegal` stays set until the next accepted start.
- R7: Elements are written in order 0..VL-1, one write each. `done` is high for exactly one cycle, in the cycle after the last write is accepted.
- R8: While `wr_valid` is high and `wr_ready` is low, the next cycle still shows `wr_valid` high with the same address, mask and data.
- R9: A start with VL = 0 gives `done` in the next cycle, with no write and no trap.
- R10: `start` and the configuration inputs are ignored while `busy` is high.
- R11: With `wr_ready` held high and no trap, `done` rises VL cycles after the cycle in which `busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken when not busy) |
| vl | input | VLW | Number of vector elements |
| dest_sub | input | 3 | Destination subvector width, 1..4 |
| src_sub | input | 3 | Source subvector width, 1..4 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| illegal | output | 1 | Sticky trap flag |
| fail_elem | output | VLW | Index of the trapping element |
| sel_addr | output | VLW | Selector read index |
| sel_data | input | 12 | Selector word for `sel_addr` |
| src_addr | output | VLW+2 | Flat index of lane 0 of the current source subvector |
| src_a_data | input | 4*DW | Group A lanes at `src_addr`..`src_addr`+3 |
| src_b_data | input | 4*DW | Group B lanes at `src_addr`..`src_addr`+3 |
| wr_valid | output | 1 | Destination write offered |
| wr_ready | input | 1 | Destination write accepted |
| wr_addr | output | VLW+2 | Flat destination index of lane 0 |
| wr_mask | output | 4 | Lane enables of the write |
| wr_data | output | 4*DW | Destination lanes |

## Verification
The hardest case to reach is a trap on an element in the middle of a run while the write port is stalling. In that case the previous elements must all land, and the faulty element must never appear on the port, even though it is being decoded during stalled cycles. The stimulus builds valid selectors for a run and then corrupts one middle element, either with a stray high bit or with a lane number beyond the source width. It drives `wr_ready` with a pseudo-random pattern, so the trap element is reached after a varied history of stalls. A start pulse with a different length during a run, followed by a clean run after a trap, shows that configuration is latched and that the flag clears.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int LANES = 4;
  localparam int FLD   = 3;
  localparam int SELW  = LANES * FLD;
  localparam int LIDXW = $clog2(LANES);
  typedef logic [LIDXW-1:0] lidx_t;
endpackage

// File: rtl/swz_decode.sv
module swz_decode
  import swz_pkg::*;
(
  input  logic [SELW-1:0] sel,
  input  logic [2:0]      dsub,
  input  logic [2:0]      ssub,
  output logic            trap,
  output logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] lane_from_a,
  output lidx_t           lane_idx [LANES]
);
  logic             hi_bad;
  logic [LANES-1:0] lane_bad;

  always_comb begin
    hi_bad = 1'b0;
    for (int b = 0; b < SELW; b++) begin
      if (sel[b] && (b >= FLD * int'(dsub))) hi_bad = 1'b1;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i]     = (3'(i) < dsub);
    assign lane_idx[i]    = sel[FLD*i +: LIDXW];
    assign lane_from_a[i] = sel[FLD*i + LIDXW];
    assign lane_bad[i]    = lane_en[i] && ({1'b0, lane_idx[i]} >= ssub);
  end

  assign trap = hi_bad | (|lane_bad);
endmodule

// File: rtl/swz_lane_mux.sv
module swz_lane_mux
  import swz_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [LANES*DW-1:0] a_lanes,
  input  logic [LANES*DW-1:0] b_lanes,
  input  logic [LANES-1:0]    lane_en,
  input  logic [LANES-1:0]    lane_from_a,
  input  lidx_t               lane_idx [LANES],
  output logic [LANES*DW-1:0] out_lanes
);
  logic [DW-1:0] a_arr [LANES];
  logic [DW-1:0] b_arr [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_unpack
    assign a_arr[j] = a_lanes[j*DW +: DW];
    assign b_arr[j] = b_lanes[j*DW +: DW];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_out
    logic [DW-1:0] pick;
    assign pick = lane_from_a[i] ? a_arr[lane_idx[i]] : b_arr[lane_idx[i]];
    assign out_lanes[i*DW +: DW] = lane_en[i] ? pick : '0;
  end
endmodule

// File: rtl/swz_ctrl.sv
module swz_ctrl #(
  parameter int VLW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  input  logic [2:0]     dsub_in,
  input  logic [2:0]     ssub_in,
  input  logic           trap,
  input  logic           wr_ready,
  output logic           busy,
  output logic           done,
  output logic           illegal,
  output logic [VLW-1:0] fail_elem,
  output logic [VLW-1:0] vidx,
  output logic [2:0]     dsub_q,
  output logic [2:0]     ssub_q,
  output logic           wr_valid
);
  logic [VLW-1:0] vl_q;

  assign wr_valid = busy & ~trap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      illegal   <= 1'b0;
      fail_elem <= '0;
      vidx      <= '0;
      vl_q      <= '0;
      dsub_q    <= 3'd1;
      ssub_q    <= 3'd1;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          illegal   <= 1'b0;
          fail_elem <= '0;
          vidx      <= '0;
          vl_q      <= vl;
          dsub_q    <= dsub_in;
          ssub_q    <= ssub_in;
          if (vl == '0) done <= 1'b1;
          else          busy <= 1'b1;
        end
      end else if (trap) begin
        busy      <= 1'b0;
        illegal   <= 1'b1;
        fail_elem <= vidx;
        done      <= 1'b1;
      end else if (wr_ready) begin
        if (vidx == vl_q - 1'b1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          vidx <= vidx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/subvec_swizzle.sv
module subvec_swizzle
  import swz_pkg::*;
#(
  parameter  int DW  = 16,
  parameter  int VLW = 6,
  localparam int AW  = VLW + LIDXW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [VLW-1:0]      vl,
  input  logic [2:0]          dest_sub,
  input  logic [2:0]          src_sub,
  output logic                busy,
  output logic                done,
  output logic                illegal,
  output logic [VLW-1:0]      fail_elem,
  output logic [VLW-1:0]      sel_addr,
  input  logic [SELW-1:0]     sel_data,
  output logic [AW-1:0]       src_addr,
  input  logic [LANES*DW-1:0] src_a_data,
  input  logic [LANES*DW-1:0] src_b_data,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [AW-1:0]       wr_addr,
  output logic [LANES-1:0]    wr_mask,
  output logic [LANES*DW-1:0] wr_data
);
  logic [VLW-1:0]   vidx;
  logic [2:0]       dsub_q, ssub_q;
  logic             trap;
  logic [LANES-1:0] lane_en, lane_from_a;
  lidx_t            lane_idx [LANES];
  logic [AW-1:0]    vidx_w;

  swz_ctrl #(.VLW(VLW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .dsub_in(dest_sub), .ssub_in(src_sub), .trap(trap), .wr_ready(wr_ready),
    .busy(busy), .done(done), .illegal(illegal), .fail_elem(fail_elem),
    .vidx(vidx), .dsub_q(dsub_q), .ssub_q(ssub_q), .wr_valid(wr_valid)
  );

  swz_decode u_dec (
    .sel(sel_data), .dsub(dsub_q), .ssub(ssub_q), .trap(trap),
    .lane_en(lane_en), .lane_from_a(lane_from_a), .lane_idx(lane_idx)
  );

  swz_lane_mux #(.DW(DW)) u_mux (
    .a_lanes(src_a_data), .b_lanes(src_b_data), .lane_en(lane_en),
    .lane_from_a(lane_from_a), .lane_idx(lane_idx), .out_lanes(wr_data)
  );

  assign vidx_w   = AW'(vidx);
  assign sel_addr = vidx;
  assign src_addr = vidx_w * AW'(ssub_q);
  assign wr_addr  = vidx_w * AW'(dsub_q);
  assign wr_mask  = lane_en;
endmodule

// File: rtl/swz_checker.sv
module swz_checker
  import swz_pkg::*;
#(
  parameter int DW  = 16,
  parameter int VLW = 6,
  parameter int AW  = VLW + 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic                illegal,
  input logic                wr_valid,
  input logic                wr_ready,
  input logic [AW-1:0]       wr_addr,
  input logic [LANES-1:0]    wr_mask,
  input logic [LANES*DW-1:0] wr_data
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_mask) && $stable(wr_data)));

  // R6
  trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_valid);

  // R6
  trap_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(illegal) |-> (done && !busy));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  valid_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (busy && !done));
endmodule

bind subvec_swizzle swz_checker #(.DW(DW), .VLW(VLW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .illegal(illegal),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_mask(wr_mask), .wr_data(wr_data)
);

// File: tb/test_subvec_swizzle.sv
module test_subvec_swizzle;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int VLW = 6;
  localparam int AW  = VLW + 2;

  typedef struct {
    int               addr;
    logic [3:0]       mask;
    logic [4*DW-1:0]  data;
  } wr_item_t;

  logic clk = 0, rst_n = 0, start = 0, wr_ready = 1;
  logic [VLW-1:0] vl = 0;
  logic [2:0] dest_sub = 1, src_sub = 1;
  logic busy, done, illegal, wr_valid;
  logic [VLW-1:0] fail_elem, sel_addr;
  logic [11:0] sel_data;
  logic [AW-1:0] src_addr, wr_addr;
  logic [4*DW-1:0] src_a_data, src_b_data, wr_data;
  logic [3:0] wr_mask;

  logic [11:0]   sel_mem [64];
  logic [DW-1:0] a_mem [256];
  logic [DW-1:0] b_mem [256];
  wr_item_t exp_q [$];
  int errors = 0, checks = 0, rmode = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subvec_swizzle #(.DW(DW), .VLW(VLW)) i_subvec_swizzle (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .dest_sub(dest_sub),
    .src_sub(src_sub), .busy(busy), .done(done), .illegal(illegal),
    .fail_elem(fail_elem), .sel_addr(sel_addr), .sel_data(sel_data),
    .src_addr(src_addr), .src_a_data(src_a_data), .src_b_data(src_b_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_mask(wr_mask), .wr_data(wr_data)
  );

  assign sel_data = sel_mem[sel_addr];
  always_comb begin
    for (int j = 0; j < 4; j++) begin
      int k;
      k = int'(src_addr) + j;
      src_a_data[j*DW +: DW] = (k < 256) ? a_mem[k] : '0;
      src_b_data[j*DW +: DW] = (k < 256) ? b_mem[k] : '0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ready pattern, changed just after each rising edge
  initial forever begin
    @(posedge clk); #1;
    wr_ready = (rmode == 0) ? 1'b1 : (($urandom % 3) != 0);
  end

  // monitor: pops expected writes and checks stalls
  logic prev_stall = 0;
  logic [AW-1:0] prev_addr = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check(wr_valid && wr_addr == prev_addr, "R8", "stalled write held",
              longint'(wr_addr), longint'(prev_addr));
      end
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R6 R7", "unexpected write addr", longint'(wr_addr), -1);
        end else begin
          wr_item_t e;
          e = exp_q.pop_front();
          check(int'(wr_addr) == e.addr, "R3 R7", "write address",
                longint'(wr_addr), longint'(e.addr));
          check(wr_mask == e.mask, "R3", "write mask",
                longint'(wr_mask), longint'(e.mask));
          check(wr_data == e.data, "R2 R3", "write data",
                longint'(wr_data), longint'(e.data));
        end
      end
      prev_stall = wr_valid && !wr_ready;
      prev_addr  = wr_addr;
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic fill(input int nvl, input int ds, input int ss);
    for (int v = 0; v < nvl; v++) begin
      logic [11:0] s;
      s = '0;
      for (int i = 0; i < ds; i++) begin
        logic [2:0] f;
        f = {1'($urandom % 2), 2'($urandom % ss)};
        s[3*i +: 3] = f;
      end
      sel_mem[v] = s;
    end
    for (int k = 0; k < 256; k++) begin
      a_mem[k] = DW'($urandom);
      b_mem[k] = DW'($urandom);
    end
  endtask

  task automatic run_op(input int nvl, input int ds, input int ss, input int rm,
                        input bit poke, input string tag);
    bit exp_trap;
    int exp_fail, n;
    exp_trap = 0; exp_fail = 0;
    for (int v = 0; v < nvl && !exp_trap; v++) begin
      wr_item_t e;
      logic [11:0] s;
      bit bad;
      s = sel_mem[v];
      bad = ((s >> (3*ds)) != 0);
      e.addr = v * ds; e.mask = '0; e.data = '0;
      for (int i = 0; i < ds; i++) begin
        int idx;
        idx = int'(s[3*i +: 2]);
        if (idx >= ss) bad = 1;
        else begin
          e.mask[i] = 1'b1;
          e.data[i*DW +: DW] = s[3*i+2] ? a_mem[v*ss + idx] : b_mem[v*ss + idx];
        end
      end
      if (bad) begin exp_trap = 1; exp_fail = v; end
      else exp_q.push_back(e);
    end
    @(negedge clk);
    rmode = rm;
    vl = VLW'(nvl); dest_sub = 3'(ds); src_sub = 3'(ss); start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (poke && n == 2) begin
        start = 1; vl = VLW'(1); dest_sub = 3'd1; src_sub = 3'd4;
      end else start = 0;
    end
    start = 0;
    check(done, tag, "done seen", longint'(done), 1);
    check(exp_q.size() == 0, tag, "pending expected writes",
          longint'(exp_q.size()), 0);
    exp_q.delete();
    check(illegal == exp_trap, tag, "illegal flag", longint'(illegal), longint'(exp_trap));
    if (exp_trap)
      check(int'(fail_elem) == exp_fail, tag, "fail element",
            longint'(fail_elem), longint'(exp_fail));
    if (rm == 0 && !exp_trap)
      check(n == nvl, "R11 R9", "cycles to done", longint'(n), longint'(nvl));
    @(negedge clk);
    check(!done && !busy, "R7", "done one cycle, idle after",
          longint'({done, busy}), 0);
    rmode = 0;
  endtask

  initial begin
    for (int k = 0; k < 64; k++) sel_mem[k] = '0;
    fill(64, 1, 1);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !illegal && !wr_valid, "R1", "reset outputs",
          longint'({busy, done, illegal, wr_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !illegal && !wr_valid, "R1", "after reset release",
          longint'({busy, done, illegal, wr_valid}), 0);

    // R2 R3 R7 R11: full width, ready high
    fill(5, 4, 4);  run_op(5, 4, 4, 0, 0, "R2 R3 R7");
    // R8: back-pressure with mixed widths
    fill(20, 2, 3); run_op(20, 2, 3, 1, 0, "R8 R3");
    // narrowest widths
    fill(3, 1, 1);  run_op(3, 1, 1, 0, 0, "R2 R3");
    fill(12, 3, 2); run_op(12, 3, 2, 1, 0, "R2 R3 R8");
    // R9: zero length
    run_op(0, 2, 2, 0, 0, "R9");
    // R4: stray high bit on element 2
    fill(6, 2, 4); sel_mem[2][6] = 1'b1; run_op(6, 2, 4, 0, 0, "R4 R6");
    // R4: top bit with dest width 3
    fill(4, 3, 4); sel_mem[0][11] = 1'b1; run_op(4, 3, 4, 1, 0, "R4 R6");
    // R5: lane index out of range on element 0
    fill(4, 2, 2); sel_mem[0][4:3] = 2'd3; run_op(4, 2, 2, 0, 0, "R5 R6");
    // R5 + R6 under back-pressure, mid-run
    fill(30, 4, 3); sel_mem[17][11:9] = 3'b011; run_op(30, 4, 3, 1, 0, "R5 R6 R8");
    // R6: flag clears on next clean run
    fill(8, 4, 4); run_op(8, 4, 4, 0, 0, "R6 R2");
    // R10: start during a run is ignored
    fill(10, 2, 2); run_op(10, 2, 2, 0, 1, "R10");
    fill(25, 4, 2); run_op(25, 4, 2, 1, 1, "R10 R8");
    // longest run
    fill(63, 4, 4); run_op(63, 4, 4, 1, 0, "R7 R3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule